// File: doc/BRIEF.md
# Drive Identification Block Streamer

This block builds the 256-word drive identification response that a storage controller returns when the host asks a device to describe itself. It then hands the response to the sector buffer as a stream of bytes. The content comes from a handful of inputs: the drive geometry (cylinders, heads and sectors per track), the total number of addressable sectors, and a flag that selects between a fixed disk and a removable packet-command optical device. The identification text fields hold fixed ASCII constants padded with spaces. Every word that no requirement names is zero.

A one-cycle `start` pulse begins a response. The block presents one byte per accepted transfer, using a valid/ready handshake. It marks the final byte with `out_last` and then falls idle until the next pulse. Internally each word keeps its high byte and low byte. On the byte stream the low byte of a word always goes out before its high byte.

Top module: `id_block_streamer`

## Requirements
- R1: After reset, and until the first `start` pulse, `out_valid` and `out_last` are low.
- R2: The clock edge that samples `start` high makes `out_valid` high from the next cycle. Bytes then leave in word order 0 to 255. Each word is sent as bits 7:0 first and then bits 15:8, so the response has 512 bytes.
- R3: `out_last` is high together with `out_valid` exactly on the 512th byte of a response, and on no other byte.
- R4: While `out_valid` is high and `out_ready` is low, the presented byte and `out_last` keep their values, and no byte is lost.
- R5: Word 0 is 0x0040 when `packet_dev` is 0. It is 0x8580 when `packet_dev` is 1.
- R6: Word 1 equals `cyls`, word 3 equals `heads` and word 6 equals `spt`.
- R7: Word 47 is 0x8080 and word 53 is 0x0002. Word 64 is 0x0003. Words 67 and 68 are both 0x0078. Words 49 and 51 are zero.
- R8: With N = `total_sectors`, words 57 and 60 are {(N>>24) mod 255, (N>>16) mod 255}. Words 58 and 61 are {(N>>8) mod 255, N[7:0]}. The first item in braces is bits 15:8.
- R9: Words 10–19 hold the text "SN0001", words 23–26 hold "2.1" and words 27–46 hold "GENERIC ATA DISK". Each text is padded with ASCII spaces (0x20) to fill its field. In each word the earlier character sits in bits 15:8.
- R10: Every word not covered by R5 to R9 is 0x0000.
- R11: A `start` pulse that arrives during a response abandons that response. A complete new response then begins at word 0.
- R12: After the handshake of the last byte, `out_valid` is low in the next cycle. It stays low until the next `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a response |
| packet_dev | input | 1 | 1 selects a removable packet-command optical device |
| cyls | input | 16 | Cylinder count |
| heads | input | 16 | Head count |
| spt | input | 16 | Sectors per track |
| total_sectors | input | 32 | Total addressable sectors |
| out_ready | input | 1 | The sector buffer accepts a byte |
| out_valid | output | 1 | A response byte is presented |
| out_byte | output | 8 | Response byte |
| out_last | output | 1 | The presented byte is the final byte |

## Verification
The assertions check the stream's framing on every cycle. They cover the silence before the first start and the first byte after each start. They also check that `out_last` falls exactly on the 512th accepted byte, that the byte holds under backpressure, and that the stream goes quiet after the final byte. The content of the response can only be shown by the bench's scenarios. That content is the field values, the modulo-255 reduction of the capacity bytes, the space-padded text and the zero words. The bench rebuilds each word from the bytes it receives, for both device types, under several ready patterns and with a restart in the middle of a response.

// File: rtl/id_pkg.sv
package id_pkg;

    localparam int TXT_CHARS = 40;
    localparam int CAP_MOD   = 255;

    localparam logic [15:0] CFG_FIXED  = 16'h0040;
    localparam logic [15:0] CFG_PACKET = 16'h8580;
    localparam logic [15:0] MULTI_WORD = 16'h8080;
    localparam logic [15:0] VALID_WORD = 16'h0002;
    localparam logic [15:0] PIO_WORD   = 16'h0003;
    localparam logic [15:0] CYCLE_WORD = 16'h0078;

    localparam int SER_FIRST = 10;
    localparam int SER_LAST  = 19;
    localparam int FW_FIRST  = 23;
    localparam int FW_LAST   = 26;
    localparam int MDL_FIRST = 27;
    localparam int MDL_LAST  = 46;

    localparam logic [8*TXT_CHARS-1:0] SER_TXT = {"SN0001", {34{8'h20}}};
    localparam logic [8*TXT_CHARS-1:0] FW_TXT  = {"2.1", {37{8'h20}}};
    localparam logic [8*TXT_CHARS-1:0] MDL_TXT = {"GENERIC ATA DISK", {24{8'h20}}};

    function automatic logic [7:0] txt_char(input logic [8*TXT_CHARS-1:0] txt, input int k);
        return txt[8*(TXT_CHARS-1-k) +: 8];
    endfunction

    function automatic logic [15:0] txt_word(input logic [8*TXT_CHARS-1:0] txt, input int wofs);
        return {txt_char(txt, 2*wofs), txt_char(txt, 2*wofs + 1)};
    endfunction

    function automatic logic [7:0] cap_mod(input logic [31:0] v);
        logic [31:0] r;
        r = v % 32'(CAP_MOD);
        return r[7:0];
    endfunction

endpackage

// File: rtl/id_word_gen.sv
module id_word_gen
    import id_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             packet_dev,
    input  logic [15:0]      cyls,
    input  logic [15:0]      heads,
    input  logic [15:0]      spt,
    input  logic [31:0]      total_sectors,
    output logic [15:0]      word
);

    logic [15:0] cap_hi_d;
    logic [15:0] cap_lo_d;
    int          w;

    always_comb begin
        cap_hi_d = {cap_mod(total_sectors >> 24), cap_mod(total_sectors >> 16)};
        cap_lo_d = {cap_mod(total_sectors >> 8), total_sectors[7:0]};
        w        = int'(idx);
        word     = 16'h0000;
        if (w >= SER_FIRST && w <= SER_LAST) begin
            word = txt_word(SER_TXT, w - SER_FIRST);
        end else if (w >= FW_FIRST && w <= FW_LAST) begin
            word = txt_word(FW_TXT, w - FW_FIRST);
        end else if (w >= MDL_FIRST && w <= MDL_LAST) begin
            word = txt_word(MDL_TXT, w - MDL_FIRST);
        end else begin
            case (w)
                0:       word = packet_dev ? CFG_PACKET : CFG_FIXED;
                1:       word = cyls;
                3:       word = heads;
                6:       word = spt;
                47:      word = MULTI_WORD;
                53:      word = VALID_WORD;
                57, 60:  word = cap_hi_d;
                58, 61:  word = cap_lo_d;
                64:      word = PIO_WORD;
                67, 68:  word = CYCLE_WORD;
                default: word = 16'h0000;
            endcase
        end
    end

endmodule

// File: rtl/id_byte_seq.sv
module id_byte_seq #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    output logic             active,
    output logic             hi_sel,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic             active;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.hi     = 1'b0;
            st_d.idx    = '0;
        end else if (st_q.active && out_ready) begin
            if (!st_q.hi) begin
                st_d.hi = 1'b1;
            end else begin
                st_d.hi = 1'b0;
                if (st_q.idx == LAST_IDX) begin
                    st_d.active = 1'b0;
                    st_d.idx    = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign hi_sel = st_q.hi;
    assign idx    = st_q.idx;
    assign last   = st_q.active && st_q.hi && (st_q.idx == LAST_IDX);

endmodule

// File: rtl/id_block_streamer.sv
module id_block_streamer #(
    parameter int WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        packet_dev,
    input  logic [15:0] cyls,
    input  logic [15:0] heads,
    input  logic [15:0] spt,
    input  logic [31:0] total_sectors,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_last
);

    localparam int IDX_W = $clog2(WORDS);

    logic             active;
    logic             hi_sel;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic [15:0]      word;

    id_byte_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .out_ready (out_ready),
        .active    (active),
        .hi_sel    (hi_sel),
        .idx       (idx),
        .last      (last)
    );

    id_word_gen #(.IDX_W(IDX_W)) u_word (
        .idx           (idx),
        .packet_dev    (packet_dev),
        .cyls          (cyls),
        .heads         (heads),
        .spt           (spt),
        .total_sectors (total_sectors),
        .word          (word)
    );

    always_comb begin
        out_valid = active;
        out_last  = last;
        out_byte  = hi_sel ? word[15:8] : word[7:0];
    end

endmodule

// File: rtl/id_stream_chk.sv
module id_stream_chk #(
    parameter int BYTES = 512
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       out_ready,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_last
);

    localparam int CNT_W = $clog2(BYTES) + 1;

    logic [CNT_W-1:0] hs_cnt_q;
    logic             seen_start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_cnt_q     <= '0;
            seen_start_q <= 1'b0;
        end else if (start) begin
            hs_cnt_q     <= '0;
            seen_start_q <= 1'b1;
        end else if (out_valid && out_ready) begin
            hs_cnt_q <= hs_cnt_q + 1'b1;
        end
    end

    a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start_q |-> (!out_valid && !out_last));

    a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (out_valid && !out_last));

    a_r3_last_at_final: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (hs_cnt_q == CNT_W'(BYTES - 1)));

    a_r3_final_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hs_cnt_q == CNT_W'(BYTES - 1)) |-> out_last);

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    a_r12_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && !start) |=> !out_valid);

endmodule

bind id_block_streamer id_stream_chk #(.BYTES(2 * WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last)
);

// File: tb/tb_id_block_streamer.sv
`timescale 1ns/1ps
module tb_id_block_streamer;

    typedef struct packed {
        logic        pkt;
        logic [15:0] cyl;
        logic [15:0] hd;
        logic [15:0] spt;
        logic [31:0] cap;
        logic [3:0]  pat;
    } cfg_t;

    localparam int NVEC = 4;
    localparam cfg_t VEC [NVEC] = '{
        '{1'b0, 16'd1024,  16'd16,    16'd63,    32'h00FC_0FC0, 4'hF},
        '{1'b1, 16'h2000,  16'h0004,  16'h0020,  32'hFFFF_FFFF, 4'h5},
        '{1'b0, 16'hFFFF,  16'h00FF,  16'hABCD,  32'h01FE_02FF, 4'hB},
        '{1'b1, 16'h0000,  16'h0000,  16'h0000,  32'h0000_0000, 4'h6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        packet_dev = 1'b0;
    logic [15:0] cyls = '0;
    logic [15:0] heads = '0;
    logic [15:0] spt = '0;
    logic [31:0] total_sectors = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    logic [7:0] got [512];

    always #2.5 clk = ~clk;

    id_block_streamer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .packet_dev(packet_dev),
        .cyls(cyls), .heads(heads), .spt(spt), .total_sectors(total_sectors),
        .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] str_ch(input string s, input int k);
        return (k < s.len()) ? 8'(s[k]) : 8'h20;
    endfunction

    function automatic logic [15:0] exp_word(input cfg_t c, input int w);
        longint unsigned n;
        string s;
        int base;
        n = longint'(c.cap);
        s = "";
        base = 0;
        if (w >= 10 && w <= 19) begin s = "SN0001"; base = 10; end
        if (w >= 23 && w <= 26) begin s = "2.1"; base = 23; end
        if (w >= 27 && w <= 46) begin s = "GENERIC ATA DISK"; base = 27; end
        if (base != 0)
            return {str_ch(s, 2*(w-base)), str_ch(s, 2*(w-base)+1)};
        if (w == 0) return c.pkt ? 16'h8580 : 16'h0040;
        if (w == 1) return c.cyl;
        if (w == 3) return c.hd;
        if (w == 6) return c.spt;
        if (w == 47) return 16'h8080;
        if (w == 53) return 16'h0002;
        if (w == 64) return 16'h0003;
        if (w == 67 || w == 68) return 16'd120;
        if (w == 57 || w == 60)
            return {8'((n >> 24) % 255), 8'((n >> 16) % 255)};
        if (w == 58 || w == 61)
            return {8'((n >> 8) % 255), 8'(n & 255)};
        return 16'h0000;
    endfunction

    function automatic string tag_of(input int w);
        if (w == 0) return "R5";
        if (w == 1 || w == 3 || w == 6) return "R6";
        if (w == 47 || w == 49 || w == 51 || w == 53 || w == 64 || w == 67 || w == 68) return "R7";
        if (w == 57 || w == 58 || w == 60 || w == 61) return "R8";
        if ((w >= 10 && w <= 19) || (w >= 23 && w <= 46)) return "R9";
        return "R10";
    endfunction

    task automatic apply_cfg(input cfg_t c);
        @(negedge clk);
        packet_dev = c.pkt;
        cyls = c.cyl;
        heads = c.hd;
        spt = c.spt;
        total_sectors = c.cap;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        out_ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(out_valid === 1'b1, "R2 valid after start", longint'(out_valid), 1);
    endtask

    task automatic collect(input logic [3:0] pat, output int n, output int lastpos);
        logic [7:0] held;
        bit held_v;
        int cyc;
        n = 0;
        lastpos = -1;
        held_v = 0;
        held = '0;
        cyc = 0;
        while (n < 512 && cyc < 5000) begin
            if (cyc != 0) @(negedge clk);
            out_ready = pat[cyc % 4];
            cyc++;
            #1;
            if (held_v && out_valid)
                chk(out_byte === held, "R4 byte held under stall", longint'(out_byte), longint'(held));
            held_v = 0;
            if (out_valid && out_ready) begin
                got[n] = out_byte;
                if (out_last && lastpos < 0) lastpos = n;
                n++;
            end else if (out_valid) begin
                held_v = 1;
                held = out_byte;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R12 idle after last byte", longint'(out_valid), 0);
    endtask

    task automatic check_words(input cfg_t c);
        for (int w = 0; w < 256; w++) begin
            logic [15:0] a;
            logic [15:0] e;
            a = {got[2*w+1], got[2*w]};
            e = exp_word(c, w);
            chk(a === e, $sformatf("%s word %0d", tag_of(w), w), longint'(a), longint'(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int lp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, ready high or low
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            out_ready = i[0];
            #1;
            chk(out_valid === 1'b0 && out_last === 1'b0, "R1 idle after reset",
                longint'({out_valid, out_last}), 0);
        end

        // table walk: R2/R3/R4/R5..R10/R12 across configurations and ready patterns
        for (int v = 0; v < NVEC; v++) begin
            apply_cfg(VEC[v]);
            pulse_start();
            collect(VEC[v].pat, n, lp);
            chk(n == 512, "R2 byte count", n, 512);
            chk(lp == 511, "R3 last on final byte", lp, 511);
            check_words(VEC[v]);
            repeat (3) @(negedge clk);
            #1;
            chk(out_valid === 1'b0, "R12 stays idle", longint'(out_valid), 0);
        end

        // R11: restart in mid-stream
        apply_cfg(VEC[2]);
        pulse_start();
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
        end
        pulse_start();
        collect(4'hF, n, lp);
        chk(n == 512, "R11 full response after restart", n, 512);
        chk(lp == 511, "R11 last after restart", lp, 511);
        chk({got[1], got[0]} === exp_word(VEC[2], 0), "R11 restart at word 0",
            longint'({got[1], got[0]}), longint'(exp_word(VEC[2], 0)));
        chk({got[3], got[2]} === exp_word(VEC[2], 1), "R11 word 1 after restart",
            longint'({got[3], got[2]}), longint'(exp_word(VEC[2], 1)));

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule